// File: doc/BRIEF.md
# Address-Event Fan-Out Router

The router takes address events from a single sender port and spreads each one across a programmable set of receivers. Behind the input port sits a connection table. A row in that table is chosen by the sender address joined with a synapse index. Each row holds a valid bit, a receiver address, a sign bit and an unsigned repeat count. When an event comes in, the router visits the rows of that sender starting at index 0. For every valid row it sends out a burst of identical output events, one for each unit of the repeat count. Each of those events carries the row's receiver address and its sign bit.

Both the input and the output use a four-phase request/acknowledge handshake. The input acknowledge stays low until every output event produced by that sender has completed its own handshake. This means the upstream source is held back one event at a time. A separate write port rewrites single rows while the router runs, which allows connectivity and weights to change during operation. If a write arrives during a walk, it is parked in a one-deep slot and applied once the walk is finished.

Top module: `aefr_fanout_router`

## Requirements
- R1: After reset `in_ack` and `out_req` are low and `wr_ready` is high, and every table row is invalid. An input event on an empty table is acknowledged and produces no output events.
- R2: A row is chosen by index `{sender, synapse}`. Each output event drives the row's stored receiver address on `out_addr` and its stored sign bit unchanged on `out_pol`.
- R3: A valid row with repeat count M produces exactly M output events. A valid row with M = 0 produces none, and the walk then moves on to the next synapse index.
- R4: The walk visits synapse indices in ascending order from 0. It stops at the first invalid row, or after index 2^SYN_W-1 has been visited.
- R5: `out_req` rises only while `out_ack` is low. `out_addr` and `out_pol` hold steady while `out_req` is high. `out_req` falls only after `out_ack` has been seen high. The next event starts only after `out_ack` has been seen low.
- R6: `in_ack` rises only after the last output event of the walk has completed. It then stays high while `in_req` stays high, with no output request, and it drops once `in_req` has been seen low.
- R7: Rows are independent. One sender may reach several receivers, and rows of different senders may name the same receiver.
- R8: A write accepted during a walk does not alter that walk. It is applied after the walk ends, and `wr_ready` stays low while the write is parked.
- R9: If a write and a new input request arrive in the same idle cycle, the write is applied first and the event uses the updated row.
- R10: Writing a row with its valid bit at 0 removes it, so later walks of that sender end at that index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_req | input | 1 | Input event request |
| in_addr | input | SRC_W | Sender address, valid while in_req is high |
| in_ack | output | 1 | Input event acknowledge |
| out_req | output | 1 | Output event request |
| out_addr | output | DST_W | Receiver address of the output event |
| out_pol | output | 1 | Sign bit of the output event |
| out_ack | input | 1 | Output event acknowledge |
| wr_en | input | 1 | One-cycle table write strobe, honoured when wr_ready is high |
| wr_src | input | SRC_W | Sender field of the row index |
| wr_syn | input | SYN_W | Synapse field of the row index |
| wr_valid | input | 1 | Valid bit written to the row |
| wr_dst | input | DST_W | Receiver address written to the row |
| wr_pol | input | 1 | Sign bit written to the row |
| wr_mag | input | MAG_W | Repeat count written to the row |
| wr_ready | output | 1 | High when a write can be accepted |

## Verification
Two activities can land in the same cycle: a table write and the start of a walk. This can happen in an idle cycle or in the middle of a walk. The bench covers both cases. In one test it raises `wr_en` and `in_req` together while idle, and it expects the output stream to already show the new row. In another test it fires a write right after the first output event of a long burst. There it expects the stream to match the old table contents, it expects `wr_ready` to be seen low, and it expects the next event to show the new row.

// File: rtl/aefr_pkg.sv
package aefr_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_FETCH,
      ST_EMIT,
      ST_RELEASE,
      ST_ACK
   } walk_state_t;
endpackage

// File: rtl/aefr_conn_table.sv
module aefr_conn_table #(
   parameter int SRC_W = 3,
   parameter int SYN_W = 2,
   parameter int DST_W = 4,
   parameter int MAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             walk_idle,
   input  logic             wr_en,
   input  logic [SRC_W+SYN_W-1:0] wr_idx,
   input  logic             wr_valid,
   input  logic [DST_W-1:0] wr_dst,
   input  logic             wr_pol,
   input  logic [MAG_W-1:0] wr_mag,
   input  logic [SRC_W+SYN_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [DST_W-1:0] rd_dst,
   output logic             rd_pol,
   output logic [MAG_W-1:0] rd_mag
);
   localparam int IDX_W  = SRC_W + SYN_W;
   localparam int DEPTH  = 1 << IDX_W;
   localparam int DATA_W = DST_W + 1 + MAG_W;

   logic [DEPTH-1:0]  vld_q;
   logic [DATA_W-1:0] dat_q [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
      end else begin
         for (int e = 0; e < DEPTH; e++) begin
            if (wr_en && wr_idx == IDX_W'(e)) vld_q[e] <= wr_valid;
         end
      end
   end

   always_ff @(posedge clk) begin
      for (int e = 0; e < DEPTH; e++) begin
         if (wr_en && wr_idx == IDX_W'(e)) dat_q[e] <= {wr_dst, wr_pol, wr_mag};
      end
   end

   assign rd_valid = vld_q[rd_idx];
   assign {rd_dst, rd_pol, rd_mag} = dat_q[rd_idx];

   // Table contents stay frozen for the whole walk
   assert_write_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> walk_idle);
endmodule

// File: rtl/aefr_wr_hold.sv
module aefr_wr_hold #(
   parameter int WR_W = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            walk_idle,
   input  logic            wr_en,
   input  logic [WR_W-1:0] wr_word,
   output logic            wr_ready,
   output logic            tbl_wr_en,
   output logic [WR_W-1:0] tbl_word
);
   logic            pend_q;
   logic [WR_W-1:0] pend_word_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         pend_word_q <= '0;
      end else if (walk_idle) begin
         pend_q <= 1'b0;
      end else if (wr_en && !pend_q) begin
         pend_q      <= 1'b1;
         pend_word_q <= wr_word;
      end
   end

   assign wr_ready  = !pend_q;
   assign tbl_wr_en = walk_idle && (pend_q || wr_en);
   assign tbl_word  = pend_q ? pend_word_q : wr_word;

   // A parked write is released on the first idle cycle
   assert_parked_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && walk_idle) |=> !pend_q);
endmodule

// File: rtl/aefr_burst_gen.sv
module aefr_burst_gen #(
   parameter int MAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [MAG_W-1:0] load_mag,
   input  logic             step,
   output logic             last
);
   logic [MAG_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    rem_q <= '0;
      else if (load) rem_q <= load_mag;
      else if (step) rem_q <= rem_q - MAG_W'(1);
   end

   assign last = (rem_q == MAG_W'(1));

   // Never count an event beyond the stored repeat count
   assert_no_underflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> rem_q != '0);
endmodule

// File: rtl/aefr_walk_ctrl.sv
module aefr_walk_ctrl
   import aefr_pkg::*;
#(
   parameter int SRC_W = 3,
   parameter int SYN_W = 2
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   in_req,
   input  logic [SRC_W-1:0]       in_addr,
   output logic                   in_ack,
   output logic                   out_req,
   input  logic                   out_ack,
   input  logic                   hold_start,
   input  logic                   ent_valid,
   input  logic                   ent_mag_zero,
   input  logic                   burst_last,
   output logic [SRC_W+SYN_W-1:0] rd_idx,
   output logic                   load,
   output logic                   step,
   output logic                   walk_idle
);
   walk_state_t      st_q, st_d;
   logic [SRC_W-1:0] src_q;
   logic [SYN_W-1:0] syn_q, syn_d;
   logic             syn_last;

   assign syn_last = (syn_q == '1);

   always_comb begin
      st_d  = st_q;
      syn_d = syn_q;
      load  = 1'b0;
      step  = 1'b0;
      case (st_q)
         ST_IDLE: begin
            if (in_req && !hold_start) begin
               st_d  = ST_FETCH;
               syn_d = '0;
            end
         end
         ST_FETCH: begin
            if (!ent_valid) begin
               st_d = ST_ACK;
            end else if (ent_mag_zero) begin
               if (syn_last) st_d = ST_ACK;
               else          syn_d = syn_q + SYN_W'(1);
            end else begin
               load = 1'b1;
               st_d = ST_EMIT;
            end
         end
         ST_EMIT: begin
            if (out_ack) st_d = ST_RELEASE;
         end
         ST_RELEASE: begin
            if (!out_ack) begin
               step = 1'b1;
               if (!burst_last) begin
                  st_d = ST_EMIT;
               end else if (syn_last) begin
                  st_d = ST_ACK;
               end else begin
                  st_d  = ST_FETCH;
                  syn_d = syn_q + SYN_W'(1);
               end
            end
         end
         ST_ACK: begin
            if (!in_req) st_d = ST_IDLE;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= ST_IDLE;
         src_q <= '0;
         syn_q <= '0;
      end else begin
         st_q  <= st_d;
         syn_q <= syn_d;
         if (st_q == ST_IDLE && st_d == ST_FETCH) src_q <= in_addr;
      end
   end

   assign rd_idx    = {src_q, syn_q};
   assign in_ack    = (st_q == ST_ACK);
   assign out_req   = (st_q == ST_EMIT);
   assign walk_idle = (st_q == ST_IDLE);

   assert_out_rise_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_req) |-> !out_ack);
   assert_in_ack_after_outputs_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(in_ack) |-> !out_ack);
   assert_in_ack_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_ack && in_req) |=> in_ack);
   assert_in_ack_drop_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(in_ack) |-> !$past(in_req));
endmodule

// File: rtl/aefr_fanout_router.sv
module aefr_fanout_router #(
   parameter int SRC_W = 3,
   parameter int SYN_W = 2,
   parameter int DST_W = 4,
   parameter int MAG_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_req,
   input  logic [SRC_W-1:0] in_addr,
   output logic             in_ack,
   output logic             out_req,
   output logic [DST_W-1:0] out_addr,
   output logic             out_pol,
   input  logic             out_ack,
   input  logic             wr_en,
   input  logic [SRC_W-1:0] wr_src,
   input  logic [SYN_W-1:0] wr_syn,
   input  logic             wr_valid,
   input  logic [DST_W-1:0] wr_dst,
   input  logic             wr_pol,
   input  logic [MAG_W-1:0] wr_mag,
   output logic             wr_ready
);
   localparam int IDX_W = SRC_W + SYN_W;
   localparam int WR_W  = IDX_W + 1 + DST_W + 1 + MAG_W;

   if (SRC_W < 1 || SYN_W < 1 || DST_W < 1 || MAG_W < 1) begin : g_bad_width
      $error("aefr_fanout_router: every width parameter must be at least 1");
   end
   if (IDX_W > 12) begin : g_bad_depth
      $error("aefr_fanout_router: table index wider than 12 bits");
   end

   logic             walk_idle, tbl_wr_en, load, step, burst_last;
   logic [WR_W-1:0]  tbl_word;
   logic [IDX_W-1:0] rd_idx;
   logic             rd_valid, rd_pol;
   logic [DST_W-1:0] rd_dst;
   logic [MAG_W-1:0] rd_mag;
   logic [IDX_W-1:0] t_idx;
   logic             t_valid, t_pol;
   logic [DST_W-1:0] t_dst;
   logic [MAG_W-1:0] t_mag;
   logic [DST_W-1:0] addr_q;
   logic             pol_q;

   aefr_wr_hold #(.WR_W(WR_W)) wr_hold_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .walk_idle (walk_idle),
      .wr_en     (wr_en),
      .wr_word   ({wr_src, wr_syn, wr_valid, wr_dst, wr_pol, wr_mag}),
      .wr_ready  (wr_ready),
      .tbl_wr_en (tbl_wr_en),
      .tbl_word  (tbl_word)
   );

   assign {t_idx, t_valid, t_dst, t_pol, t_mag} = tbl_word;

   aefr_conn_table #(.SRC_W(SRC_W), .SYN_W(SYN_W), .DST_W(DST_W), .MAG_W(MAG_W)) table_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .walk_idle (walk_idle),
      .wr_en     (tbl_wr_en),
      .wr_idx    (t_idx),
      .wr_valid  (t_valid),
      .wr_dst    (t_dst),
      .wr_pol    (t_pol),
      .wr_mag    (t_mag),
      .rd_idx    (rd_idx),
      .rd_valid  (rd_valid),
      .rd_dst    (rd_dst),
      .rd_pol    (rd_pol),
      .rd_mag    (rd_mag)
   );

   aefr_walk_ctrl #(.SRC_W(SRC_W), .SYN_W(SYN_W)) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_req       (in_req),
      .in_addr      (in_addr),
      .in_ack       (in_ack),
      .out_req      (out_req),
      .out_ack      (out_ack),
      .hold_start   (tbl_wr_en),
      .ent_valid    (rd_valid),
      .ent_mag_zero (rd_mag == '0),
      .burst_last   (burst_last),
      .rd_idx       (rd_idx),
      .load         (load),
      .step         (step),
      .walk_idle    (walk_idle)
   );

   aefr_burst_gen #(.MAG_W(MAG_W)) burst_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .load_mag (rd_mag),
      .step     (step),
      .last     (burst_last)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         pol_q  <= 1'b0;
      end else if (load) begin
         addr_q <= rd_dst;
         pol_q  <= rd_pol;
      end
   end

   assign out_addr = addr_q;
   assign out_pol  = pol_q;

   assert_out_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (out_req && $past(out_req)) |-> ($stable(out_addr) && $stable(out_pol)));
   assert_out_fall_after_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_req) |-> $past(out_ack));
endmodule

// File: tb/aefr_fanout_router_tb.sv
module aefr_fanout_router_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int SRC_W = 3;
   localparam int SYN_W = 2;
   localparam int DST_W = 4;
   localparam int MAG_W = 3;
   localparam int NSYN  = 1 << SYN_W;
   localparam int DEPTH = 1 << (SRC_W + SYN_W);

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_req = 1'b0;
   logic [SRC_W-1:0] in_addr = '0;
   logic in_ack, out_req, out_pol, wr_ready;
   logic [DST_W-1:0] out_addr;
   logic out_ack = 1'b0;
   logic wr_en = 1'b0;
   logic [SRC_W-1:0] wr_src = '0;
   logic [SYN_W-1:0] wr_syn = '0;
   logic wr_valid = 1'b0;
   logic [DST_W-1:0] wr_dst = '0;
   logic wr_pol = 1'b0;
   logic [MAG_W-1:0] wr_mag = '0;

   int n_checks = 0;
   int n_fail = 0;

   bit m_vld [DEPTH];
   int m_dst [DEPTH];
   bit m_pol [DEPTH];
   int m_mag [DEPTH];

   int exp_a [64];
   bit exp_p [64];
   int exp_n;
   int got_a [64];
   bit got_p [64];
   int got_n;
   bit saw_ready_low;
   bit hs_bad;

   always #(CLK_PERIOD/2) clk = ~clk;

   aefr_fanout_router #(.SRC_W(SRC_W), .SYN_W(SYN_W), .DST_W(DST_W), .MAG_W(MAG_W)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .in_req(in_req), .in_addr(in_addr), .in_ack(in_ack),
      .out_req(out_req), .out_addr(out_addr), .out_pol(out_pol), .out_ack(out_ack),
      .wr_en(wr_en), .wr_src(wr_src), .wr_syn(wr_syn), .wr_valid(wr_valid),
      .wr_dst(wr_dst), .wr_pol(wr_pol), .wr_mag(wr_mag), .wr_ready(wr_ready)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_write(input int s, input int y, input bit v, input int d, input bit p, input int m);
      m_vld[s*NSYN+y] = v;
      m_dst[s*NSYN+y] = d;
      m_pol[s*NSYN+y] = p;
      m_mag[s*NSYN+y] = m;
   endtask

   task automatic drive_write(input int s, input int y, input bit v, input int d, input bit p, input int m);
      wr_src = SRC_W'(s); wr_syn = SYN_W'(y); wr_valid = v;
      wr_dst = DST_W'(d); wr_pol = p; wr_mag = MAG_W'(m);
      wr_en = 1'b1;
   endtask

   task automatic t_write(input int s, input int y, input bit v, input int d, input bit p, input int m);
      @(negedge clk);
      for (int g = 0; g < 100 && !wr_ready; g++) @(negedge clk);
      drive_write(s, y, v, d, p, m);
      @(negedge clk);
      wr_en = 1'b0;
      model_write(s, y, v, d, p, m);
   endtask

   task automatic build_expected(input int s);
      exp_n = 0;
      for (int y = 0; y < NSYN; y++) begin
         if (!m_vld[s*NSYN+y]) break;
         for (int k = 0; k < m_mag[s*NSYN+y]; k++) begin
            exp_a[exp_n] = m_dst[s*NSYN+y];
            exp_p[exp_n] = m_pol[s*NSYN+y];
            exp_n++;
         end
      end
   endtask

   // Runs one input event; mode 1 writes mid-walk, mode 2 writes in the request cycle
   task automatic run_event(input int s, input int mode,
                            input int ws, input int wy, input bit wv, input int wd, input bit wp, input int wm);
      bit   seen;
      bit   wr_done;
      int   hold_a;
      bit   hold_p;
      got_n = 0; seen = 0; wr_done = 0; saw_ready_low = 0; hs_bad = 0;
      hold_a = 0; hold_p = 0;
      @(negedge clk);
      in_addr = SRC_W'(s);
      in_req  = 1'b1;
      if (mode == 2) begin
         drive_write(ws, wy, wv, wd, wp, wm);
         @(negedge clk);
         wr_en = 1'b0;
      end
      for (int g = 0; g < 2000; g++) begin
         @(negedge clk);
         if (wr_en) wr_en = 1'b0;
         if (!wr_ready) saw_ready_low = 1;
         if (in_ack) break;
         if (out_req && !out_ack) begin
            if (!seen) begin
               seen = 1;
               hold_a = int'(out_addr); hold_p = out_pol;
               if (got_n < 64) begin
                  got_a[got_n] = int'(out_addr); got_p[got_n] = out_pol;
               end
               got_n++;
               if (mode == 1 && !wr_done) begin
                  drive_write(ws, wy, wv, wd, wp, wm);
                  wr_done = 1;
               end
            end else begin
               if (int'(out_addr) != hold_a || out_pol != hold_p) hs_bad = 1;
               out_ack = 1'b1;
            end
         end else if (!out_req && out_ack) begin
            out_ack = 1'b0;
            seen = 0;
         end else if (!out_req && seen) begin
            hs_bad = 1;
         end
      end
      check(in_ack, "R6 input acknowledge reached", int'(in_ack), 1);
      check(!hs_bad, "R5 output handshake and stable fields", int'(hs_bad), 0);
      for (int g = 0; g < 3; g++) begin
         @(negedge clk);
         if (!in_ack || out_req) hs_bad = 1;
      end
      check(!hs_bad, "R6 in_ack held without output while in_req high", int'(hs_bad), 0);
      in_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check(!in_ack, "R6 in_ack drops after in_req low", int'(in_ack), 0);
   endtask

   task automatic compare_stream(input string req);
      bit ok = (got_n == exp_n);
      int bad = -1;
      if (ok) begin
         for (int i = 0; i < exp_n; i++) begin
            if (got_a[i] != exp_a[i] || got_p[i] != exp_p[i]) begin
               ok = 0;
               if (bad < 0) bad = i;
            end
         end
      end
      if (got_n != exp_n) check(0, {req, " event count"}, got_n, exp_n);
      else if (!ok) check(0, {req, " event addr*2+pol"}, got_a[bad]*2 + int'(got_p[bad]), exp_a[bad]*2 + int'(exp_p[bad]));
      else check(1, req, got_n, exp_n);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!in_ack, "R1 in_ack low after reset", int'(in_ack), 0);
      check(!out_req, "R1 out_req low after reset", int'(out_req), 0);
      check(wr_ready, "R1 wr_ready high after reset", int'(wr_ready), 1);
      build_expected(5);
      run_event(5, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R1 empty table gives no events");
   endtask

   task automatic t_basic();
      t_write(1, 0, 1, 3, 0, 2);
      t_write(1, 1, 1, 9, 1, 1);
      build_expected(1);
      run_event(1, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R2 R3 R7 divergent stream of sender 1");
   endtask

   task automatic t_zero_mag();
      t_write(2, 0, 1, 7, 1, 0);
      t_write(2, 1, 1, 5, 1, 3);
      build_expected(2);
      run_event(2, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R3 zero repeat count skipped");
   endtask

   task automatic t_full_walk();
      t_write(3, 0, 1, 1, 0, 1);
      t_write(3, 1, 1, 2, 1, 2);
      t_write(3, 2, 1, 4, 0, 1);
      t_write(3, 3, 1, 15, 1, 7);
      build_expected(3);
      run_event(3, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R4 walk reaches last index");
   endtask

   task automatic t_gap();
      t_write(4, 0, 1, 6, 0, 2);
      t_write(4, 2, 1, 8, 1, 3);
      build_expected(4);
      run_event(4, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R4 walk stops at first invalid row");
   endtask

   task automatic t_converge();
      t_write(6, 0, 1, 3, 1, 2);
      build_expected(6);
      run_event(6, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R7 second sender reaches shared receiver");
   endtask

   task automatic t_held_write();
      build_expected(3);
      run_event(3, 1, 3, 3, 1, 0, 0, 1);
      compare_stream("R8 walk uses contents before parked write");
      check(saw_ready_low, "R8 wr_ready low while write parked", int'(saw_ready_low), 1);
      model_write(3, 3, 1, 0, 0, 1);
      build_expected(3);
      run_event(3, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R8 parked write applied after walk");
   endtask

   task automatic t_same_cycle();
      model_write(4, 1, 1, 12, 0, 2);
      build_expected(4);
      run_event(4, 2, 4, 1, 1, 12, 0, 2);
      compare_stream("R9 write before same-cycle event");
   endtask

   task automatic t_remove();
      t_write(1, 1, 0, 0, 0, 0);
      build_expected(1);
      run_event(1, 0, 0, 0, 0, 0, 0, 0);
      compare_stream("R10 removed row truncates walk");
   endtask

   initial begin
      for (int i = 0; i < DEPTH; i++) model_write(i / NSYN, i % NSYN, 0, 0, 0, 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_zero_mag();
      t_full_walk();
      t_gap();
      t_converge();
      t_held_write();
      t_same_cycle();
      t_remove();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule